// File: doc/BRIEF.md
# External Bus Hand-Off Arbiter

This block sits between a processor core's external memory interface and an outside bus master. The outside master asks for the bus with an active-low request. The arbiter answers by turning off the core's address, data, select and strobe drivers. It then asserts an active-low grant and stalls the core until the request goes away. The request is synchronized before use. A grant never cuts into an external access that is in flight: it is given in the cycle after that access finishes. When one instruction makes two accesses, a parameter chooses whether the bus may change hands between them.

A run-ahead mode input lets the core keep executing while the bus is lent out. The core is stalled only in cycles where it has an external access ready. A separate active-low "hung" output reports exactly those cycles in which the core is blocked by the grant. Arbitration also runs while the chip reset is asserted. During reset, access activity from the core is ignored and the grant simply follows the synchronized request.

Top module: `ext_bus_grant_arbiter`

## Requirements
- R1: `br_n` passes through SYNC_STAGES (default 2) flip-flops before the state machine sees it. With no access in flight and the bus idle, `bg_n` goes low on the SYNC_STAGES+1-th rising edge after `br_n` goes low.
- R2: While granted, `bg_n`=0 and `bus_oe`=0 together. `bg_n`=0 never occurs with `bus_oe`=1, and when not granted `bg_n`=1 and `bus_oe`=1.
- R3: If the synchronized request is seen while `acc_busy`=1 and `acc_end`=0, no grant is given. The grant follows on the edge after the cycle with `acc_busy`=1 and `acc_end`=1.
- R4: The end of an access with `acc_pair_first`=1 (first of two accesses in one instruction) allows a grant when PAIR_SPLIT=1. When PAIR_SPLIT=0 the grant waits for the end of the second access.
- R5: With `go_mode`=0, `core_halt`=1 in every granted cycle, whatever `acc_req` is.
- R6: With `go_mode`=1, `core_halt`=1 in a granted cycle only when `acc_req`=1, and 0 otherwise.
- R7: `bg_hung_n`=0 exactly in granted cycles with `acc_req`=1.
- R8: After `br_n` returns high, `bg_n` and `bus_oe` both return to 1 on the SYNC_STAGES+1-th edge. `core_halt` goes to 0 and `bg_hung_n` goes to 1 in that same cycle.
- R9: After a release there is one turnaround cycle in which a still-present request is not honoured. A request held through the release is re-granted two edges after `bg_n` rises.
- R10: While `rst_n`=0, the `acc_*` inputs are ignored and the grant follows the synchronized request with the R1 latency, in both directions. With `br_n` high during reset, the outputs read `bg_n`=1, `bus_oe`=1, `core_halt`=0 and `bg_hung_n`=1.
- R11: If the request is withdrawn while the arbiter waits for an access to end, it returns to idle and no grant is given when the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Chip reset, active low, synchronous |
| br_n | input | 1 | Bus request from the outside master, active low, asynchronous |
| acc_req | input | 1 | Core has an external access ready to start |
| acc_busy | input | 1 | An external access occupies the bus this cycle |
| acc_end | input | 1 | This is the last cycle of the access in flight |
| acc_pair_first | input | 1 | The access ending now is the first of two in one instruction |
| go_mode | input | 1 | 1: core runs on while granted, stalling only on external accesses |
| bg_n | output | 1 | Bus grant, active low |
| bg_hung_n | output | 1 | Core blocked by the grant, active low |
| bus_oe | output | 1 | Enable for the address, data, select and strobe drivers |
| core_halt | output | 1 | Stall to the core |

## Verification
The bench counts the exact edge on which the grant appears after a request in three cases: bus idle, access in flight, and access pair. A design that skipped a synchronizer stage or granted mid-access would move `bg_n` a cycle early and be seen. A second instance with the pair split disabled runs on the same stimulus, so a wrong variant choice shows as a grant one cycle too soon or too late. The bench re-requests across a release to catch a missing turnaround cycle, and withdraws a request during a wait to catch a stale grant. It also toggles access inputs during reset, which an arbiter that did not ignore them would wrongly follow.

// File: rtl/xbg_pkg.sv
package xbg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_GRANT = 2'd2,
      ST_REL   = 2'd3
   } arb_state_e;
endpackage

// File: rtl/xbg_req_sync.sv
module xbg_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic req_n_i,
   output logic req_o
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] stg;

   // Each stage powers up in the "no request" level so the chain is
   // defined from time zero without depending on reset.
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic q = 1'b1;
      if (s == 0) begin : g_first
         always_ff @(posedge clk) q <= req_n_i;
      end else begin : g_next
         always_ff @(posedge clk) q <= stg[s-1];
      end
      assign stg[s] = q;
   end

   assign req_o = ~stg[LAST];
endmodule

// File: rtl/xbg_fsm.sv
module xbg_fsm
   import xbg_pkg::*;
#(
   parameter bit PAIR_SPLIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       acc_busy,
   input  logic       acc_end,
   input  logic       acc_pair_first,
   output arb_state_e state,
   output logic       grant_nxt
);
   arb_state_e state_q = ST_IDLE;
   arb_state_e nxt;
   logic       busy_g;
   logic       end_g;
   logic       end_ok;

   // Core activity is meaningless while the chip is in reset.
   assign busy_g = acc_busy & rst_n;
   assign end_g  = acc_end  & rst_n;

   if (PAIR_SPLIT) begin : g_split
      assign end_ok = end_g;
   end else begin : g_hold
      assign end_ok = end_g & ~acc_pair_first;
   end

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_s) nxt = (!busy_g || end_ok) ? ST_GRANT : ST_WAIT;
         end
         ST_WAIT: begin
            if (!req_s)                nxt = ST_IDLE;
            else if (!busy_g || end_ok) nxt = ST_GRANT;
         end
         ST_GRANT: begin
            if (!req_s) nxt = ST_REL;
         end
         ST_REL: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= req_s ? ST_GRANT : ST_IDLE;
      else        state_q <= nxt;
   end

   assign state     = state_q;
   assign grant_nxt = rst_n ? (nxt == ST_GRANT) : req_s;

   // R3
   no_grant_mid_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE || state_q == ST_WAIT) && acc_busy && !acc_end)
      |=> (state_q != ST_GRANT));

   // R9
   release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REL) |=> (state_q == ST_IDLE));

   // R11
   wait_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !req_s) |=> (state_q == ST_IDLE));

   if (!PAIR_SPLIT) begin : g_pair_chk
      // R4
      pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (state_q != ST_GRANT && acc_busy && acc_end && acc_pair_first)
         |=> (state_q != ST_GRANT));
   end
endmodule

// File: rtl/xbg_drv.sv
module xbg_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_nxt,
   input  logic acc_req,
   input  logic go_mode,
   output logic bg_n,
   output logic bus_oe,
   output logic core_halt,
   output logic bg_hung_n
);
   logic grant_q = 1'b0;
   logic oe_q    = 1'b1;

   always_ff @(posedge clk) begin
      grant_q <= grant_nxt;
      oe_q    <= ~grant_nxt;
   end

   assign bg_n      = ~grant_q;
   assign bus_oe    = oe_q;
   assign core_halt = grant_q & (~go_mode | acc_req);
   assign bg_hung_n = ~(grant_q & acc_req);

   // R5
   halt_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_mode && !bg_n) |-> core_halt);

   // R6
   halt_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_mode && !acc_req) |-> !core_halt);

   // R7
   hung_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bg_hung_n |-> (!bg_n && acc_req));
endmodule

// File: rtl/ext_bus_grant_arbiter.sv
module ext_bus_grant_arbiter
   import xbg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit PAIR_SPLIT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic br_n,
   input  logic acc_req,
   input  logic acc_busy,
   input  logic acc_end,
   input  logic acc_pair_first,
   input  logic go_mode,
   output logic bg_n,
   output logic bg_hung_n,
   output logic bus_oe,
   output logic core_halt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       req_s;
   logic       grant_nxt;
   arb_state_e state;

   xbg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .req_n_i (br_n),
      .req_o   (req_s)
   );

   xbg_fsm #(.PAIR_SPLIT(PAIR_SPLIT)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_s          (req_s),
      .acc_busy       (acc_busy),
      .acc_end        (acc_end),
      .acc_pair_first (acc_pair_first),
      .state          (state),
      .grant_nxt      (grant_nxt)
   );

   xbg_drv u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_nxt (grant_nxt),
      .acc_req   (acc_req),
      .go_mode   (go_mode),
      .bg_n      (bg_n),
      .bus_oe    (bus_oe),
      .core_halt (core_halt),
      .bg_hung_n (bg_hung_n)
   );

   // R2
   grant_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bg_n && bus_oe));

   // R2
   grant_tracks_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GRANT) == !bg_n);

   // R1
   grant_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bg_n) |-> $past(req_s));

   // R8
   release_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bg_n) |-> !$past(req_s));
endmodule

// File: tb/ext_bus_grant_arbiter_tb.sv
module ext_bus_grant_arbiter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic br_n = 1'b1;
   logic acc_req = 1'b0, acc_busy = 1'b0, acc_end = 1'b0, acc_pair_first = 1'b0, go_mode = 1'b0;
   logic bg_n, bg_hung_n, bus_oe, core_halt;
   logic np_bg_n, np_hung_n, np_oe, np_halt;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   ext_bus_grant_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .br_n(br_n), .acc_req(acc_req), .acc_busy(acc_busy),
      .acc_end(acc_end), .acc_pair_first(acc_pair_first), .go_mode(go_mode),
      .bg_n(bg_n), .bg_hung_n(bg_hung_n), .bus_oe(bus_oe), .core_halt(core_halt));

   ext_bus_grant_arbiter #(.SYNC_STAGES(2), .PAIR_SPLIT(1'b0)) u_dut_np (
      .clk(clk), .rst_n(rst_n), .br_n(br_n), .acc_req(acc_req), .acc_busy(acc_busy),
      .acc_end(acc_end), .acc_pair_first(acc_pair_first), .go_mode(go_mode),
      .bg_n(np_bg_n), .bg_hung_n(np_hung_n), .bus_oe(np_oe), .core_halt(np_halt));

   // {br_n, busy, end, pair_first, acc_req, go_mode, bg_n, bus_oe, halt, hung_n}
   localparam int NV = 54;
   localparam logic [9:0] VEC [NV] = '{
      // R1 R2 R5 R7 R8: idle grant, go_mode off, release
      10'b100000_1101, 10'b000000_1101, 10'b000000_1101, 10'b000000_1101,
      10'b000000_0011, 10'b000010_0010, 10'b100010_0010, 10'b100010_0010,
      10'b100010_0010, 10'b100010_1101, 10'b100000_1101,
      // R6 R7: go_mode on
      10'b000001_1101, 10'b000001_1101, 10'b000001_1101, 10'b000001_0001,
      10'b000011_0010, 10'b000001_0001, 10'b100011_0010, 10'b100011_0010,
      10'b100011_0010, 10'b100011_1101, 10'b100000_1101,
      // R3: request during an access
      10'b010000_1101, 10'b010000_1101, 10'b010000_1101, 10'b010000_1101,
      10'b011000_1101, 10'b000000_0011,
      // R9: re-request across a release
      10'b100000_0011, 10'b000000_0011, 10'b000000_0011, 10'b000000_1101,
      10'b000000_1101, 10'b000000_0011, 10'b100000_0011, 10'b100000_0011,
      10'b100000_0011, 10'b100000_1101, 10'b100000_1101,
      // R4: split between paired accesses
      10'b010100_1101, 10'b010100_1101, 10'b011100_1101, 10'b000010_0010,
      10'b100010_0010, 10'b100010_0010, 10'b100010_0010, 10'b100010_1101,
      10'b100000_1101,
      // R11: withdraw while waiting
      10'b010000_1101, 10'b110000_1101, 10'b110000_1101, 10'b110000_1101,
      10'b111000_1101, 10'b100000_1101
   };

   function automatic string vec_tag(input int i);
      if (i < 11) return "R1";
      if (i < 22) return "R6";
      if (i < 28) return "R3";
      if (i < 39) return "R9";
      if (i < 48) return "R4";
      return "R11";
   endfunction

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {bg_n,oe,halt,hung_n} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic b, input logic bu, input logic e, input logic p,
                        input logic r, input logic g);
      @(negedge clk);
      br_n = b; acc_busy = bu; acc_end = e; acc_pair_first = p; acc_req = r; go_mode = g;
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R10: reset state with no request
      repeat (4) drive(1, 0, 0, 0, 0, 0);
      chk("R10", {bg_n, bus_oe, core_halt, bg_hung_n}, 4'b1101);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) drive(1, 0, 0, 0, 0, 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
         chk(vec_tag(i), {bg_n, bus_oe, core_halt, bg_hung_n}, VEC[i][3:0]);
      end

      // R4: same pair, split vs held variant
      drive(0, 1, 0, 1, 0, 0);
      drive(0, 1, 0, 1, 0, 0);
      drive(0, 1, 1, 1, 0, 0);
      drive(0, 1, 1, 0, 0, 0);
      chk("R4", {bg_n, bus_oe, 2'b00}, 4'b0000);
      chk("R4", {np_bg_n, np_oe, 2'b00}, 4'b1100);
      drive(0, 0, 0, 0, 0, 0);
      chk("R4", {np_bg_n, np_oe, np_halt, np_hung_n}, 4'b0011);
      repeat (6) drive(1, 0, 0, 0, 0, 0);
      chk("R8", {bg_n, bus_oe, np_bg_n, np_oe}, 4'b1111);

      // R10: request during reset, access inputs ignored
      @(negedge clk); rst_n = 1'b0;
      drive(0, 1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 0, 0);
      chk("R10", {bg_n, bus_oe, 2'b00}, 4'b1100);
      drive(1, 1, 0, 0, 0, 0);
      chk("R10", {bg_n, bus_oe, core_halt, bg_hung_n}, 4'b0011);
      drive(1, 1, 0, 0, 0, 0);
      drive(1, 1, 0, 0, 0, 0);
      chk("R10", {bg_n, bus_oe, 2'b00}, 4'b0000);
      drive(1, 1, 0, 0, 0, 0);
      chk("R10", {bg_n, bus_oe, core_halt, bg_hung_n}, 4'b1101);
      @(negedge clk); rst_n = 1'b1;
      drive(1, 0, 0, 0, 0, 0);
      chk("R2", {bg_n, bus_oe, core_halt, bg_hung_n}, 4'b1101);

      finish_run();
   end
endmodule